// File: doc/BRIEF.md
# Window Watchdog Timer

This block is a supervisory timer that software must service inside a time window. A 7-bit down-counter is clocked by ticks from a divider chain: a fixed divide stage (4096 by default) followed by a programmable power-of-two stage. Software services the timer by rewriting the counter. A rewrite that comes too soon, while the counter is still above a programmable 7-bit window value, requests a system reset. A reset is also requested when software stops servicing and the counter decrements from 0x40 to 0x3F.

An early-warning flag is raised one tick before that rollover, so software has a last chance to act. The flag drives an interrupt output through an enable bit. Once software has enabled the timer, it cannot disable it again. Only the block's own reset request, or the external reset, returns the timer to its idle state.

Configuration is written through a simple single-cycle write port with four addresses:

| Address | Bits used | Effect |
|---|---|---|
| 0 | `wr_data[7]` | Sets the enable bit |
| 0 | `wr_data[6:0]` | Counter value (a write here is a refresh) |
| 1 | `wr_data[6:0]` | Window value |
| 2 | low bits | Prescaler exponent |
| 2 | `wr_data[4]` | Interrupt enable |
| 3 | any data | Clears the early flag |

Top module: `win_watchdog`

## Requirements
- R1: After the external reset, the outputs and registers hold these values:
  - the counter reads 0x7F and the window is 0x7F;
  - the prescaler exponent is 0 and the interrupt enable is 0;
  - the timer is disabled;
  - the early flag, the interrupt and the reset request are all 0.
- R2: The enable bit is set by an address-0 write with `wr_data[7]`=1. A later address-0 write with `wr_data[7]`=0 leaves the timer enabled. While the timer is disabled, the counter holds its value.
- R3: While enabled, the counter decrements by one every DIV_FIXED·2^p clock cycles, where p is the prescaler exponent. The exponent is taken from `wr_data[1:0]`, or from `wr_data[2:0]` when WIDE_PSC is set. The tick period restarts from zero on every counter write.
- R4: A reset request is raised when a tick arrives with the counter at 0x40. This happens (load & 0x3F)+1 ticks after the load, and the counter never shows a value below 0x40 while enabled.
- R5: A counter write with `wr_data[6]`=0 raises an immediate reset request if the timer is enabled, or is being enabled by that same write.
- R6: While enabled, a counter write raises a reset request if the counter is above the window value. At or below the window value, the write reloads the counter with `wr_data[6:0]` and no reset is requested.
- R7: The early flag is set on the tick that moves the counter from 0x41 to 0x40. Any address-3 write clears it. The interrupt output is the flag gated by the interrupt enable (address 2, `wr_data[4]`).
- R8: The reset request is a single-cycle pulse. In the cycle it is high, the counter, window, prescaler, interrupt enable, enable bit and flag have already returned to their R1 values.
- R9: A counter write while the timer is disabled, and not enabling it, loads the counter without a reset request, even when the value is below 0x40.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low external reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Write data |
| cnt_o | output | 7 | Current counter value |
| en_o | output | 1 | Timer enabled |
| flag_o | output | 1 | Early-warning flag |
| irq_o | output | 1 | Early-warning interrupt |
| rst_req_o | output | 1 | Reset request pulse |

## Verification
On every cycle, the assertions check the following:
- the reset pulse lasts one cycle and leaves the registers in their R1 values;
- the enable bit never falls except through a reset request;
- the counter holds while disabled and steps down by exactly one per tick;
- the counter never drops below 0x40 while enabled;
- the flag rises on the 0x41-to-0x40 tick.

Only the bench's scenarios can show the following:
- the tick period for each prescaler exponent;
- the exact cycle of the timeout pulse;
- the split between early and in-window refreshes against chosen window values;
- the effect of the interrupt enable gate and of the flag clear.

// File: rtl/win_watchdog.sv
module win_watchdog #(
  parameter int DIV_FIXED = 4096,
  parameter bit WIDE_PSC  = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic [6:0] cnt_o,
  output logic       en_o,
  output logic       flag_o,
  output logic       irq_o,
  output logic       rst_req_o
);
  localparam int EXP_W = WIDE_PSC ? 3 : 2;
  localparam int MAX_EXP = (1 << EXP_W) - 1;
  localparam int PRE_W = $clog2(DIV_FIXED) + MAX_EXP;
  localparam logic [PRE_W:0] BASE = (PRE_W+1)'(DIV_FIXED);
  localparam logic [6:0] CNT_INIT = 7'h7F;
  localparam logic [6:0] CNT_LOW  = 7'h40;

  logic [6:0]       cnt_q, win_q;
  logic [EXP_W-1:0] exp_q;
  logic [PRE_W-1:0] pre_q;
  logic             ie_q, en_q, flag_q, rst_q;

  logic [PRE_W:0] span;
  logic wr_cnt, wr_win, wr_cfg, wr_clr;
  logic tick, going_en, bad_low, early, underflow, trig;

  assign wr_cnt = wr_en && (wr_addr == 2'd0);
  assign wr_win = wr_en && (wr_addr == 2'd1);
  assign wr_cfg = wr_en && (wr_addr == 2'd2);
  assign wr_clr = wr_en && (wr_addr == 2'd3);

  assign span      = BASE << exp_q;
  assign tick      = en_q && ({1'b0, pre_q} == span - 1'b1);
  assign going_en  = en_q || (wr_cnt && wr_data[7]);
  assign bad_low   = wr_cnt && going_en && !wr_data[6];
  assign early     = wr_cnt && en_q && (cnt_q > win_q);
  assign underflow = tick && (cnt_q == CNT_LOW);
  assign trig      = bad_low || early || underflow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= CNT_INIT;
      win_q  <= CNT_INIT;
      exp_q  <= '0;
      pre_q  <= '0;
      ie_q   <= 1'b0;
      en_q   <= 1'b0;
      flag_q <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      rst_q <= trig;
      if (trig) begin
        cnt_q  <= CNT_INIT;
        win_q  <= CNT_INIT;
        exp_q  <= '0;
        pre_q  <= '0;
        ie_q   <= 1'b0;
        en_q   <= 1'b0;
        flag_q <= 1'b0;
      end else begin
        if (wr_win) win_q <= wr_data[6:0];
        if (wr_cfg) begin
          exp_q <= wr_data[EXP_W-1:0];
          ie_q  <= wr_data[4];
        end
        if (wr_cnt) begin
          cnt_q <= wr_data[6:0];
          pre_q <= '0;
          if (wr_data[7]) en_q <= 1'b1;
        end else if (en_q) begin
          pre_q <= tick ? '0 : pre_q + 1'b1;
          if (tick) cnt_q <= cnt_q - 1'b1;
        end
        if (wr_clr) flag_q <= 1'b0;
        else if (tick && !wr_cnt && cnt_q == 7'h41) flag_q <= 1'b1;
      end
    end
  end

  assign cnt_o     = cnt_q;
  assign en_o      = en_q;
  assign flag_o    = flag_q;
  assign irq_o     = flag_q && ie_q;
  assign rst_req_o = rst_q;

  p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |=> !rst_req_o);
  p_regs_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> (cnt_o == CNT_INIT && !en_o && !flag_o && win_q == CNT_INIT));
  p_en_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_o && !trig) |=> en_o);
  p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_o && !wr_cnt) |=> $stable(cnt_o));
  p_step_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_cnt && cnt_o > CNT_LOW) |=> cnt_o == $past(cnt_o) - 7'd1);
  p_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
    en_o |-> cnt_o[6]);
  p_flag_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_en && cnt_o == 7'h41) |=> flag_o);
endmodule

// File: tb/win_watchdog_tb.sv
`timescale 1ns/1ps
module win_watchdog_tb_top;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [6:0] cnt_o;
  logic en_o, flag_o, irq_o, rst_req_o;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  win_watchdog #(.DIV_FIXED(DIV), .WIDE_PSC(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cnt_o(cnt_o), .en_o(en_o), .flag_o(flag_o), .irq_o(irq_o), .rst_req_o(rst_req_o));

  // {psc[2:0], load[6:0], window[6:0], wait[15:0], refresh[6:0], expect_reset}
  localparam logic [40:0] VEC [7] = '{
    {3'd0, 7'h7F, 7'h7F, 16'd10,  7'h7F, 1'b0},
    {3'd0, 7'h7F, 7'h50, 16'd10,  7'h7F, 1'b1},
    {3'd1, 7'h60, 7'h5C, 16'd40,  7'h70, 1'b0},
    {3'd2, 7'h50, 7'h50, 16'd20,  7'h45, 1'b0},
    {3'd3, 7'h7F, 7'h40, 16'd100, 7'h7F, 1'b1},
    {3'd0, 7'h48, 7'h48, 16'd30,  7'h3F, 1'b1},
    {3'd5, 7'h44, 7'h7F, 16'd300, 7'h7F, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    do_reset();
    chk("R1 cnt", cnt_o, 7'h7F);
    chk("R1 en", en_o, 0);
    chk("R1 flag", flag_o, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 rst", rst_req_o, 0);
    repeat (50) @(negedge clk);
    chk("R2 hold while disabled", cnt_o, 7'h7F);
    wr(2'd0, 8'h30);
    chk("R9 load below 0x40 disabled", cnt_o, 7'h30);
    chk("R9 no reset", rst_req_o, 0);
    chk("R9 still disabled", en_o, 0);

    for (int i = 0; i < 7; i++) begin
      logic [40:0] v;
      int period;
      v = VEC[i];
      period = DIV << v[40:38];
      do_reset();
      wr(2'd2, {5'd0, v[40:38]});
      wr(2'd1, {1'b0, v[30:24]});
      wr(2'd0, {1'b1, v[37:31]});
      repeat (int'(v[23:8])) @(negedge clk);
      chk("R3 tick count", cnt_o, v[37:31] - 7'(int'(v[23:8]) / period));
      wr(2'd0, {1'b0, v[7:1]});
      if (v[0]) begin
        chk(v[7] ? "R6 early refresh reset" : "R5 low write reset", rst_req_o, 1);
        chk("R8 cnt after reset", cnt_o, 7'h7F);
        chk("R8 disabled after reset", en_o, 0);
      end else begin
        chk("R6 in-window reload", cnt_o, v[7:1]);
        chk("R6 no reset", rst_req_o, 0);
      end
    end

    do_reset();
    wr(2'd1, 8'h7F);
    wr(2'd0, 8'hFF);
    wr(2'd0, 8'h7F);
    chk("R2 cannot disable", en_o, 1);

    do_reset();
    wr(2'd2, 8'h10);
    wr(2'd0, 8'hC2);
    repeat (8) @(negedge clk);
    chk("R7 flag at 0x40", flag_o, 1);
    chk("R7 irq enabled", irq_o, 1);
    chk("R4 cnt at 0x40", cnt_o, 7'h40);
    repeat (3) @(negedge clk);
    chk("R4 no early timeout", rst_req_o, 0);
    @(negedge clk);
    chk("R4 timeout pulse", rst_req_o, 1);
    chk("R8 cnt", cnt_o, 7'h7F);
    chk("R8 flag", flag_o, 0);
    chk("R8 irq", irq_o, 0);
    @(negedge clk);
    chk("R8 single pulse", rst_req_o, 0);

    do_reset();
    wr(2'd2, 8'h01);
    wr(2'd0, 8'hC1);
    repeat (8) @(negedge clk);
    chk("R7 flag set", flag_o, 1);
    chk("R7 irq gated", irq_o, 0);
    chk("R3 period 8", cnt_o, 7'h40);
    wr(2'd3, 8'h00);
    chk("R7 flag cleared", flag_o, 0);
    wr(2'd0, 8'h7F);
    chk("R6 reload in window", cnt_o, 7'h7F);
    chk("R6 no reset", rst_req_o, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule